// File: doc/BRIEF.md
# Three-Wire Configuration Word Loader

This block takes 24-bit configuration words from a three-wire serial port: a serial clock, a data line and a load strobe. It oversamples all three wires from a faster system clock. Each serial rising edge shifts one data bit into a shift register, most significant bit first. When the load strobe rises, the most recent 24 bits are captured. The two lowest bits of that word pick one of four configuration registers. The upper 22 bits are written into the picked register once the strobe has been held high long enough.

The serial side can keep clocking at any time. Only the bits in the shift register at the moment the strobe rises take part in a write. There are two ways a strobe can be refused. It is refused if it rises too soon after the last serial clock edge. It is also refused if it falls before its minimum width. Both limits are counted in system-clock cycles. Every write raises a single-cycle update pulse, tagged with the index of the register that was written.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, all four configuration registers read zero and the update pulse is low.
- R2: A write stores word bits 23 down to 2 into the selected register. The word is sent most significant bit first, so bit 23 is shifted in first.
- R3: Word bits 1:0 select the register by index: 00 selects 0, 01 selects 1, 10 selects 2, 11 selects 3. Register k sits at cfg_o[k*22 +: 22].
- R4: A write leaves the three unselected registers unchanged.
- R5: Each write raises upd_o for exactly one system-clock cycle. upd_idx_o carries the index of the written register.
- R6: When more than 24 bits are shifted before the strobe rises, only the last 24 take part in the write.
- R7: A strobe that rises fewer than LE_SETUP_CYC system-clock cycles after the last serial rising edge writes nothing. The shifted word stays in place, so a later valid strobe writes it.
- R8: A strobe that is high for fewer than LE_WIDTH_CYC system-clock cycles writes nothing.
- R9: A strobe held high for a long time produces exactly one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial wires |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| sdata_i | input | 1 | Serial data, most significant bit first |
| sle_i | input | 1 | Load strobe; its rising edge captures the word |
| cfg_o | output | 88 | Four 22-bit configuration registers, register k at bits k*22 +: 22 |
| upd_o | output | 1 | One-cycle pulse on each register write |
| upd_idx_o | output | 2 | Index of the register written with upd_o |

## Verification
The assertions assume that the three serial wires hold each level for several system-clock cycles. They also assume that the strobe never rises in the same synchronized cycle as a serial clock edge. The bench holds each serial clock phase for four system cycles and changes the data only while the serial clock is low. It drives all stimulus on the falling system-clock edge, so every wire passes through the synchronizers with the same delay. Timing violations are made on purpose in two ways. One test raises the strobe a single cycle after the last serial edge. Another sends a one-cycle strobe.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
  localparam int unsigned WORD_W = 24;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned PAY_W  = WORD_W - SEL_W;
  localparam int unsigned NREGS  = 1 << SEL_W;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/scl_frontend.sv
module scl_frontend #(
  parameter int unsigned WORD_W       = 24,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned LE_SETUP_CYC = 4,
  parameter int unsigned LE_WIDTH_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              sle_i,
  output logic              commit_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned SET_W  = $clog2(LE_SETUP_CYC + 1);
  localparam int unsigned HOLD_W = $clog2(LE_WIDTH_CYC + 1);
  localparam logic [SET_W-1:0]  SET_MAX  = SET_W'(LE_SETUP_CYC);
  localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(LE_WIDTH_CYC);
  localparam logic [HOLD_W-1:0] HOLD_FIRE = HOLD_W'(LE_WIDTH_CYC - 1);

  logic [2:0] raw_w, syn_w;
  assign raw_w = {sle_i, sdata_i, sclk_i};

  // all three wires share one delay so data stays aligned to its clock edge
  for (genvar g = 0; g < 3; g++) begin : g_sync
    scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_w[g]),
      .q_o   (syn_w[g])
    );
  end

  logic sclk_s, sdata_s, sle_s;
  assign sclk_s  = syn_w[0];
  assign sdata_s = syn_w[1];
  assign sle_s   = syn_w[2];

  logic sclk_q, sle_q;
  logic sclk_rise, le_rise;
  logic [WORD_W-1:0] shift_q, snap_q;
  logic [SET_W-1:0]  since_clk_q;
  logic [HOLD_W-1:0] hold_q;
  logic              armed_q;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign le_rise   = sle_s & ~sle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q      <= 1'b0;
      sle_q       <= 1'b0;
      shift_q     <= '0;
      snap_q      <= '0;
      since_clk_q <= SET_MAX;
      hold_q      <= '0;
      armed_q     <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      sle_q  <= sle_s;
      if (sclk_rise) shift_q <= {shift_q[WORD_W-2:0], sdata_s};
      if (sclk_rise)                 since_clk_q <= '0;
      else if (since_clk_q < SET_MAX) since_clk_q <= since_clk_q + 1'b1;
      if (le_rise) begin
        snap_q  <= shift_q;
        armed_q <= (since_clk_q >= SET_MAX);
      end
      if (!sle_s)                hold_q <= '0;
      else if (hold_q < HOLD_MAX) hold_q <= hold_q + 1'b1;
    end
  end

  assign commit_o = sle_s & armed_q & (hold_q == HOLD_FIRE);
  assign word_o   = snap_q;

  // R8
  commit_le_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (sle_s && $past(sle_s)));

  // R9
  single_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
endmodule

// File: rtl/scl_latch_bank.sv
module scl_latch_bank #(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned SEL_W  = 2,
  localparam int unsigned PAY_W = WORD_W - SEL_W,
  localparam int unsigned NREGS = 1 << SEL_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic [WORD_W-1:0]      word_i,
  output logic [NREGS*PAY_W-1:0] cfg_o,
  output logic                   upd_o,
  output logic [SEL_W-1:0]       upd_idx_o
);
  logic [SEL_W-1:0] sel_w;
  logic [PAY_W-1:0] pay_w;
  assign sel_w = word_i[SEL_W-1:0];
  assign pay_w = word_i[WORD_W-1:SEL_W];

  logic [PAY_W-1:0] regs_q [NREGS];

  for (genvar k = 0; k < NREGS; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       regs_q[k] <= '0;
      else if (wr_i && sel_w == SEL_W'(k)) regs_q[k] <= pay_w;
    end
    assign cfg_o[k*PAY_W +: PAY_W] = regs_q[k];

    // R4
    unsel_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_o && upd_idx_o != SEL_W'(k)) |-> $stable(regs_q[k]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_o     <= 1'b0;
      upd_idx_o <= '0;
    end else begin
      upd_o <= wr_i;
      if (wr_i) upd_idx_o <= sel_w;
    end
  end

  // R5
  upd_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);

  // R2
  payload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (regs_q[upd_idx_o] == $past(pay_w)));
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import serial_cfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned LE_SETUP_CYC = 4,
  parameter int unsigned LE_WIDTH_CYC = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   sdata_i,
  input  logic                   sle_i,
  output logic [NREGS*PAY_W-1:0] cfg_o,
  output logic                   upd_o,
  output logic [SEL_W-1:0]       upd_idx_o
);
  logic              commit_w;
  logic [WORD_W-1:0] word_w;

  scl_frontend #(
    .WORD_W      (WORD_W),
    .SYNC_STAGES (SYNC_STAGES),
    .LE_SETUP_CYC(LE_SETUP_CYC),
    .LE_WIDTH_CYC(LE_WIDTH_CYC)
  ) u_front (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_i  (sclk_i),
    .sdata_i (sdata_i),
    .sle_i   (sle_i),
    .commit_o(commit_w),
    .word_o  (word_w)
  );

  scl_latch_bank #(
    .WORD_W(WORD_W),
    .SEL_W (SEL_W)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (commit_w),
    .word_i   (word_w),
    .cfg_o    (cfg_o),
    .upd_o    (upd_o),
    .upd_idx_o(upd_idx_o)
  );
endmodule

// File: tb/serial_cfg_loader_tb_top.sv
module serial_cfg_loader_tb_top;
  localparam int PAY_W = 22;
  localparam int NREGS = 4;
  localparam int HALF  = 4;
  localparam int NVEC  = 8;
  localparam logic [23:0] VEC [NVEC] = '{
    24'hA5C3F1, 24'h3B7E24, 24'hD00DF6, 24'h6E91B7,
    24'h1F2E3C, 24'hC7A859, 24'h84B27E, 24'hF0F0FF
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk_i = 1'b0, sdata_i = 1'b0, sle_i = 1'b0;
  logic [NREGS*PAY_W-1:0] cfg_o;
  logic upd_o;
  logic [1:0] upd_idx_o;

  serial_cfg_loader dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sdata_i(sdata_i),
    .sle_i(sle_i), .cfg_o(cfg_o), .upd_o(upd_o), .upd_idx_o(upd_idx_o)
  );

  always #4 clk_i = ~clk_i;

  int checks = 0, errors = 0, strobes = 0, cycles = 0;
  logic [1:0] last_idx = '0;
  logic [PAY_W-1:0] model [NREGS];
  bit done = 0;

  always @(negedge clk_i) begin
    cycles++;
    if (upd_o) begin
      strobes++;
      last_idx = upd_idx_o;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    for (int k = 0; k < NREGS; k++)
      chk(req, 32'(cfg_o[k*PAY_W +: PAY_W]), 32'(model[k]));
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sclk_i = 1'b0; sdata_i = v[i];
      repeat (HALF) @(negedge clk_i);
      sclk_i = 1'b1;
      repeat (HALF) @(negedge clk_i);
    end
    sclk_i = 1'b0;
  endtask

  task automatic pulse_le(input int gap, input int width);
    repeat (gap) @(negedge clk_i);
    sle_i = 1'b1;
    repeat (width) @(negedge clk_i);
    sle_i = 1'b0;
    repeat (10) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    int s0;
    logic [23:0] w;
    for (int k = 0; k < NREGS; k++) model[k] = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk_regs("R1");
    chk("R1", 32'(upd_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk_regs("R1");

    // table walk: R2 R3 R4 R5
    for (int v = 0; v < NVEC; v++) begin
      w = VEC[v];
      s0 = strobes;
      send_bits(32'(w), 24);
      pulse_le(4, 6);
      model[w[1:0]] = w[23:2];
      chk_regs("R2/R3/R4");
      chk("R5 count", 32'(strobes - s0), 1);
      chk("R5 idx", 32'(last_idx), 32'(w[1:0]));
    end

    // R6: leading extra bits discarded
    s0 = strobes;
    send_bits({6'h3F, 2'b00, 24'h5A5A5E}, 30);
    pulse_le(4, 6);
    model[2] = 22'(24'h5A5A5E >> 2);
    chk_regs("R6");
    chk("R6 count", 32'(strobes - s0), 1);

    // R7: strobe too soon after last serial edge
    s0 = strobes;
    w = 24'h123455;
    send_bits(32'(w >> 1), 23);
    sclk_i = 1'b0; sdata_i = w[0];
    repeat (HALF) @(negedge clk_i);
    sclk_i = 1'b1;
    @(negedge clk_i);
    sle_i = 1'b1;
    repeat (6) @(negedge clk_i);
    sle_i = 1'b0;
    repeat (HALF) @(negedge clk_i);
    sclk_i = 1'b0;
    repeat (10) @(negedge clk_i);
    chk("R7 no write", 32'(strobes - s0), 0);
    chk_regs("R7");
    pulse_le(4, 6);
    model[1] = w[23:2];
    chk("R7 later write", 32'(strobes - s0), 1);
    chk_regs("R7");

    // R8: strobe too short
    s0 = strobes;
    send_bits(32'h00ABCD, 24);
    pulse_le(4, 1);
    chk("R8 no write", 32'(strobes - s0), 0);
    chk_regs("R8");

    // R9: long strobe gives one write
    s0 = strobes;
    send_bits(32'hFEDCBB, 24);
    pulse_le(4, 40);
    model[3] = 22'(24'hFEDCBB >> 2);
    chk("R9 count", 32'(strobes - s0), 1);
    chk_regs("R9");

    finish_run();
  end

  initial begin
    while (cycles < 150000) @(negedge clk_i);
    errors++;
    $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
    finish_run();
  end
endmodule